// File: doc/BRIEF.md
# Byte-Store Target for a Core-Side Request Port

This block is a small synchronous byte memory that sits on the target side of a point-to-point request/response link. A master presents a command, an address and write data, and holds them until the target raises its accept strobe. A write command stores the byte at the addressed location. A read command returns the stored byte on the read-data port, with a data-valid response code.

Requests are handled one at a time. A request that is still in progress is never overlapped by a new one. The target decodes only the part of the address space covered by its memory depth. Any address at or above that depth is left unanswered, and the target stays idle so that another target can serve the upper range. Unknown command codes are treated like the idle command.

Top module: `byte_store_target`

## Requirements
- R1: While the synchronous active-high reset `rst` is held, and on the first cycle after it, `rsp_accept` is 0, `rsp_code` is 00 and `rsp_rdata` is 0.
- R2: Command code 001 (write) with an address below DEPTH stores `req_wdata` at that address. `rsp_accept` is then high in the cycle after the second rising edge that samples the request. During a write, `rsp_code` stays 00.
- R3: Command code 010 (read) with an address below DEPTH sets `rsp_accept` high, `rsp_code` to 01 and `rsp_rdata` to the stored byte, all in the same cycle. That cycle follows the second rising edge that samples the request.
- R4: `rsp_accept` is a single-cycle pulse, and it appears only for a write or read request with an in-range address that was sampled two edges earlier.
- R5: `rsp_code` takes only the values 00 (no response) and 01 (data valid). Every 01 returns to 00 in the next cycle.
- R6: `rsp_rdata` changes only in a cycle in which `rsp_code` is 01. At all other times it holds the byte from the last read.
- R7: A write or read whose address is DEPTH or greater gets no accept and no response code. It leaves every stored byte unchanged, including the one whose index equals the low address bits.
- R8: Command code 000 and the unused codes 011 through 111 get no accept and no response, and they store nothing.
- R9: If the master issues a read in the cycle in which a write to the same address is accepted, the read returns the newly written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_cmd | input | 3 | Request command: 000 idle, 001 write, 010 read, others ignored |
| req_addr | input | ADDR_W (13) | Byte address of the request |
| req_wdata | input | DATA_W (8) | Byte to store on a write |
| rsp_accept | output | 1 | One-cycle pulse: request accepted, master may issue the next one |
| rsp_code | output | 2 | Response code: 00 none, 01 read data valid |
| rsp_rdata | output | DATA_W (8) | Byte returned by the last read |

## Verification
Every accepted request produces its accept pulse, and for a read also its code and data, in the cycle after the second rising edge that sees the request. The first edge moves the controller out of idle and starts the memory read. The second edge registers the results. The bench drives inputs on falling edges. It checks that nothing has appeared one falling edge after a request, that everything is present at the second falling edge, and that accept and code have cleared again at the third. For ignored requests, the bench waits several falling edges and checks that the outputs stay quiet. It then reads back the location the request could have changed.

// File: rtl/bst_pkg.sv
package bst_pkg;

  localparam logic [2:0] CMD_IDLE  = 3'b000;
  localparam logic [2:0] CMD_WRITE = 3'b001;
  localparam logic [2:0] CMD_READ  = 3'b010;

  localparam logic [1:0] RSP_NONE  = 2'b00;
  localparam logic [1:0] RSP_VALID = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } ctrl_state_e;

endpackage

// File: rtl/bst_decode.sv
module bst_decode #(
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 256
) (
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_wr,
  output logic              hit_rd
);
  import bst_pkg::*;

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

  logic in_range;

  assign in_range = ({1'b0, addr} < LIMIT);
  assign hit_wr   = in_range && (cmd == CMD_WRITE);
  assign hit_rd   = in_range && (cmd == CMD_READ);

endmodule

// File: rtl/bst_ram.sv
module bst_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_q <= store[rd_idx];
    end
  end

endmodule

// File: rtl/bst_ctrl.sv
module bst_ctrl #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_wr,
  input  logic              hit_rd,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ram_q,
  output logic              ram_wr_en,
  output logic [IDX_W-1:0]  ram_wr_idx,
  output logic [DATA_W-1:0] ram_wr_data,
  output logic              ram_rd_en,
  output logic              accept,
  output logic [1:0]        code,
  output logic [DATA_W-1:0] rdata
);
  import bst_pkg::*;

  ctrl_state_e       state;
  logic [IDX_W-1:0]  held_idx;
  logic [DATA_W-1:0] held_data;

  // The memory is read from the live request address while idle, so the
  // byte is ready by the time the read state registers it.
  assign ram_rd_en   = (state == ST_IDLE);
  assign ram_wr_en   = (state == ST_WRITE);
  assign ram_wr_idx  = held_idx;
  assign ram_wr_data = held_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      accept    <= 1'b0;
      code      <= RSP_NONE;
      rdata     <= '0;
      held_idx  <= '0;
      held_data <= '0;
    end else begin
      accept <= 1'b0;
      code   <= RSP_NONE;
      unique case (state)
        ST_IDLE: begin
          if (hit_wr) begin
            state     <= ST_WRITE;
            held_idx  <= req_idx;
            held_data <= req_wdata;
          end else if (hit_rd) begin
            state <= ST_READ;
          end
        end
        ST_WRITE: begin
          accept <= 1'b1;
          state  <= ST_IDLE;
        end
        ST_READ: begin
          accept <= 1'b1;
          code   <= RSP_VALID;
          rdata  <= ram_q;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/byte_store_target.sv
module byte_store_target #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_accept,
  output logic [1:0]        rsp_code,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int IDX_W = $clog2(DEPTH);

  logic              hit_wr;
  logic              hit_rd;
  logic              ram_wr_en;
  logic              ram_rd_en;
  logic [IDX_W-1:0]  ram_wr_idx;
  logic [DATA_W-1:0] ram_wr_data;
  logic [DATA_W-1:0] ram_q;
  logic [IDX_W-1:0]  req_idx;

  assign req_idx = req_addr[IDX_W-1:0];

  bst_decode #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
  ) u_decode (
    .cmd    (req_cmd),
    .addr   (req_addr),
    .hit_wr (hit_wr),
    .hit_rd (hit_rd)
  );

  bst_ctrl #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .hit_wr      (hit_wr),
    .hit_rd      (hit_rd),
    .req_idx     (req_idx),
    .req_wdata   (req_wdata),
    .ram_q       (ram_q),
    .ram_wr_en   (ram_wr_en),
    .ram_wr_idx  (ram_wr_idx),
    .ram_wr_data (ram_wr_data),
    .ram_rd_en   (ram_rd_en),
    .accept      (rsp_accept),
    .code        (rsp_code),
    .rdata       (rsp_rdata)
  );

  bst_ram #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W)
  ) u_ram (
    .clk     (clk),
    .wr_en   (ram_wr_en),
    .wr_idx  (ram_wr_idx),
    .wr_data (ram_wr_data),
    .rd_en   (ram_rd_en),
    .rd_idx  (req_idx),
    .rd_q    (ram_q)
  );

endmodule

// File: rtl/byte_store_target_chk.sv
module byte_store_target_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        req_cmd,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_accept,
  input logic [1:0]        rsp_code,
  input logic [DATA_W-1:0] rsp_rdata
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

  // R4
  accept_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_accept |=> !rsp_accept);

  // R4 R7 R8
  accept_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_accept |-> (({1'b0, $past(req_addr, 2)} < LIMIT) &&
                    ($past(req_cmd, 2) == 3'b001 || $past(req_cmd, 2) == 3'b010)));

  // R5
  code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_code != 2'b10 && rsp_code != 2'b11);

  // R5
  code_return_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_code == 2'b01) |=> (rsp_code == 2'b00));

  // R3
  code_with_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_code == 2'b01) |-> rsp_accept);

  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rsp_rdata) |-> (rsp_code == 2'b01));

endmodule

bind byte_store_target byte_store_target_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_cmd    (req_cmd),
  .req_addr   (req_addr),
  .rsp_accept (rsp_accept),
  .rsp_code   (rsp_code),
  .rsp_rdata  (rsp_rdata)
);

// File: tb/byte_store_target_bench.sv
module byte_store_target_bench;

  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 256;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        req_cmd = 3'b000;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_accept;
  logic [1:0]        rsp_code;
  logic [DATA_W-1:0] rsp_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [DATA_W-1:0] last_rd = '0;

  always #4 clk = ~clk;

  byte_store_target #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_byte_store_target (
    .clk        (clk),
    .rst        (rst),
    .req_cmd    (req_cmd),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_accept (rsp_accept),
    .rsp_code   (rsp_code),
    .rsp_rdata  (rsp_rdata)
  );

  function automatic logic [DATA_W-1:0] pat(input int a, input int salt);
    return DATA_W'((a * 37 + 11 + salt * 101) % 256);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Accepted request; called just after a falling edge.
  task automatic accepted(input logic [2:0] c, input int a, input logic [DATA_W-1:0] d,
                          input logic [DATA_W-1:0] exp_rd);
    req_cmd = c; req_addr = ADDR_W'(a); req_wdata = d;
    @(negedge clk);
    check(c == 3'b001 ? "R2 early accept" : "R3 early accept", int'(rsp_accept), 0);
    @(negedge clk);
    if (c == 3'b001) begin
      check("R2 accept", int'(rsp_accept), 1);
      check("R2 code", int'(rsp_code), 0);
    end else begin
      check("R3 accept", int'(rsp_accept), 1);
      check("R3 code", int'(rsp_code), 1);
      check("R3 rdata", int'(rsp_rdata), int'(exp_rd));
      last_rd = exp_rd;
    end
    req_cmd = 3'b000;
    @(negedge clk);
    check("R4 accept clears", int'(rsp_accept), 0);
    check("R5 code clears", int'(rsp_code), 0);
    check("R6 rdata held", int'(rsp_rdata), int'(last_rd));
  endtask

  // Request that must be ignored.
  task automatic ignored(input string req, input logic [2:0] c, input int a,
                         input logic [DATA_W-1:0] d);
    req_cmd = c; req_addr = ADDR_W'(a); req_wdata = d;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check({req, " no accept"}, int'(rsp_accept), 0);
      check({req, " no code"}, int'(rsp_code), 0);
    end
    req_cmd = 3'b000;
    @(negedge clk);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 60000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <= 60000 cycles", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 accept in reset", int'(rsp_accept), 0);
    check("R1 code in reset", int'(rsp_code), 0);
    check("R1 rdata in reset", int'(rsp_rdata), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 accept after reset", int'(rsp_accept), 0);
    check("R1 code after reset", int'(rsp_code), 0);

    // R2 / R3: fill every location, then read every location back
    for (int a = 0; a < DEPTH; a++) accepted(3'b001, a, pat(a, 0), 8'h00);
    for (int a = 0; a < DEPTH; a++) accepted(3'b010, a, 8'h00, pat(a, 0));

    // R7: out-of-range writes and reads, then aliasing locations unchanged
    for (int k = 0; k < 8; k++) begin
      int far_a;
      far_a = (k < 4) ? DEPTH + k * 61 : (1 << ADDR_W) - 1 - k;
      ignored("R7 write", 3'b001, far_a, pat(far_a, 3));
      ignored("R7 read", 3'b010, far_a, 8'h00);
      accepted(3'b010, far_a % DEPTH, 8'h00, pat(far_a % DEPTH, 0));
    end

    // R8: idle and unused codes store nothing
    for (int c = 0; c < 8; c++) begin
      if (c == 1 || c == 2) continue;
      ignored("R8 cmd", 3'(c), c * 9, pat(c, 5));
      accepted(3'b010, c * 9, 8'h00, pat(c * 9, 0));
    end

    // R9: read issued in the cycle the write to the same address is accepted
    for (int a = 3; a < DEPTH; a += 50) begin
      req_cmd = 3'b001; req_addr = ADDR_W'(a); req_wdata = pat(a, 7);
      @(negedge clk);
      @(negedge clk);
      check("R9 write accept", int'(rsp_accept), 1);
      req_cmd = 3'b010;
      @(negedge clk);
      check("R9 no early accept", int'(rsp_accept), 0);
      @(negedge clk);
      check("R9 read accept", int'(rsp_accept), 1);
      check("R9 read code", int'(rsp_code), 1);
      check("R9 new data", int'(rsp_rdata), int'(pat(a, 7)));
      last_rd = pat(a, 7);
      req_cmd = 3'b000;
      @(negedge clk);
      check("R6 rdata held after R9", int'(rsp_rdata), int'(last_rd));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule